// File: doc/BRIEF.md
# Looping Pattern Segment Sequencer

This block streams user pattern words out of a segment memory onto a 32-bit transmit word stream. The block holds a table of sequencer programs. Each program has a small fixed number of slots, and each slot names a segment by its first word address, its length in words and a play mode. A slot can play its segment once, repeat it a programmed number of times, or repeat it with no end. When a request names a program, the block plays the slots of that program in index order and emits one word per clock with no gaps, including across segment and slot boundaries.

A request can carry a new program while another one is playing. The request either takes effect at once, or waits until the segment pass in progress ends. While a deferred request is waiting, a later deferred request overwrites it. When the last slot of a program completes, the stream stops and a done flag rises. A program whose first slot is unused completes at once and emits no words. Software fills the table through a write port, one slot at a time. The segment memory sits outside the block and is read through a synchronous port that has one cycle of latency.

Top module: `pat_seq`

## Requirements
- R1: While reset is asserted and after it is released, with no request yet, `out_valid`, `done` and `mem_en` are low.
- R2: A slot in mode 1 (once) emits `len+1` words from addresses `addr`, `addr+1`, ... in order, one time, and play then moves to the next slot.
- R3: A slot in mode 2 (count) plays its segment `cnt+1` times back to back before play moves to the next slot.
- R4: A slot in mode 3 (forever) repeats its segment with no end. Play never moves past it, and `done` stays low.
- R5: Slots play in index order 0 to NSLOT-1. A program ends after its last slot, or before the first slot in mode 0 (unused). `done` is high from the cycle after the final valid word until the next request, and stays low while words are valid.
- R6: `out_data` carries the memory word at the issued address one cycle after the read. The first word is valid on the second clock edge after the request edge. Within a program, `out_valid` stays high on every cycle until the final word.
- R7: A request with `req_now=1` during play ends the current program at once. The single word already read still comes out, and the first word of the new program follows on the next cycle.
- R8: A request with `req_now=0` during play lets the segment pass in progress finish, then starts the new program on the next cycle with no gap. This includes a request that arrives in the cycle of the last word.
- R9: A second deferred request that arrives before the boundary replaces the pending program.
- R10: A write with `cfg_we` stores mode, address, length (words minus 1) and count (plays minus 1) into slot `cfg_slot` of program `cfg_prog`. There are 16 programs. The mode codes are 0 unused, 1 once, 2 count and 3 forever.
- R11: A request while idle starts its program at once, whatever the value of `req_now`. A program whose slot 0 is unused raises `done` and emits no valid word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Slot write strobe |
| cfg_prog | input | 4 | Program written |
| cfg_slot | input | 2 | Slot written |
| cfg_mode | input | 2 | Play mode: 0 unused, 1 once, 2 count, 3 forever |
| cfg_addr | input | 16 | First word address of the segment |
| cfg_len | input | 11 | Segment length in words minus 1 |
| cfg_cnt | input | 16 | Play count minus 1 for count mode |
| req | input | 1 | Program request strobe |
| req_prog | input | 4 | Requested program |
| req_now | input | 1 | 1: switch at once, 0: switch at the end of the segment pass |
| mem_en | output | 1 | Segment memory read enable |
| mem_addr | output | 16 | Segment memory word address |
| mem_rdata | input | 32 | Segment memory read data, one cycle after the read |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Output pattern word |
| done | output | 1 | Program completed |

## Verification
The hardest cases to reach are deferred requests that land on or just before a segment pass boundary. One is a request in the very cycle that issues the last word of a pass. Another is a second request that overwrites the first before the boundary. The bench counts output words from the request edge and drives each switch request at a chosen word index. This places the request on a known issued word, and the expected cut point is the first pass end at or after that word. Random programs with random switch points and switch kinds then vary the boundary positions across once and count slots.

// File: rtl/pat_seq.sv
module pat_seq #(
  parameter int NPROG = 16,
  parameter int NSLOT = 4,
  parameter int AW = 16,
  parameter int LW = 11,
  parameter int CW = 16,
  parameter int DW = 32,
  localparam int PW = $clog2(NPROG),
  localparam int SW = $clog2(NSLOT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [PW-1:0] cfg_prog,
  input  logic [SW-1:0] cfg_slot,
  input  logic [1:0]    cfg_mode,
  input  logic [AW-1:0] cfg_addr,
  input  logic [LW-1:0] cfg_len,
  input  logic [CW-1:0] cfg_cnt,
  input  logic          req,
  input  logic [PW-1:0] req_prog,
  input  logic          req_now,
  output logic          mem_en,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          done
);
  localparam int NE = NPROG * NSLOT;
  localparam int IW = $clog2(NE);

  logic [1:0]    t_mode [NE];
  logic [AW-1:0] t_addr [NE];
  logic [LW-1:0] t_len  [NE];
  logic [CW-1:0] t_cnt  [NE];

  logic          run, pend, done_q, vld;
  logic [PW-1:0] prog, pprog;
  logic [SW-1:0] slot;
  logic [LW-1:0] woff;
  logic [CW-1:0] rep;

  logic [IW-1:0] widx, idx, nidx, lidx;
  logic          at_end, last_slot, dreq, ld_req, ld, ld_empty, rep_more, stay;
  logic [PW-1:0] ld_prog;

  assign widx = IW'(cfg_prog) * IW'(NSLOT) + IW'(cfg_slot);
  assign idx  = IW'(prog) * IW'(NSLOT) + IW'(slot);
  assign nidx = (slot == SW'(NSLOT - 1)) ? idx : idx + IW'(1);
  assign last_slot = (slot == SW'(NSLOT - 1)) || (t_mode[nidx] == 2'd0);
  assign at_end = (woff == t_len[idx]);

  assign dreq    = req & ~req_now;
  assign ld_req  = req & (req_now | ~run);
  assign ld      = ld_req | (run & at_end & (pend | dreq));
  assign ld_prog = (ld_req | dreq) ? req_prog : pprog;
  assign lidx    = IW'(ld_prog) * IW'(NSLOT);
  assign ld_empty = (t_mode[lidx] == 2'd0);

  assign stay     = (t_mode[idx] == 2'd3);
  assign rep_more = (t_mode[idx] == 2'd2) && (rep != t_cnt[idx]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NE; i++) t_mode[i] <= 2'd0;
    end else if (cfg_we) begin
      t_mode[widx] <= cfg_mode;
    end
  end

  always_ff @(posedge clk) begin
    if (cfg_we) begin
      t_addr[widx] <= cfg_addr;
      t_len[widx]  <= cfg_len;
      t_cnt[widx]  <= cfg_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      pend   <= 1'b0;
      done_q <= 1'b0;
      vld    <= 1'b0;
      prog   <= '0;
      pprog  <= '0;
      slot   <= '0;
      woff   <= '0;
      rep    <= '0;
    end else begin
      vld <= run;
      if (ld) begin
        prog   <= ld_prog;
        slot   <= '0;
        woff   <= '0;
        rep    <= '0;
        pend   <= 1'b0;
        run    <= ~ld_empty;
        done_q <= ld_empty;
      end else if (run) begin
        if (dreq) begin
          pend  <= 1'b1;
          pprog <= req_prog;
        end
        if (!at_end) begin
          woff <= woff + LW'(1);
        end else begin
          woff <= '0;
          if (stay) begin
            rep <= rep;
          end else if (rep_more) begin
            rep <= rep + CW'(1);
          end else if (!last_slot) begin
            slot <= slot + SW'(1);
            rep  <= '0;
          end else begin
            run    <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign mem_en    = run;
  assign mem_addr  = t_addr[idx] + AW'(woff);
  assign out_valid = vld;
  assign out_data  = mem_rdata;
  assign done      = done_q & ~vld;
endmodule

// File: rtl/pat_seq_chk.sv
module pat_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic mem_en,
  input logic out_valid,
  input logic done,
  input logic req
);
  // R6
  read_gives_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |=> out_valid);

  // R6
  no_read_no_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_en |=> !out_valid);

  // R5
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!out_valid && !mem_en));

  // R5
  done_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !$past(mem_en));

  // R5
  done_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !req) |=> done);
endmodule

bind pat_seq pat_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_en(mem_en),
  .out_valid(out_valid), .done(done), .req(req)
);

// File: tb/sim_pat_seq.sv
module sim_pat_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_prog = '0;
  logic [1:0]  cfg_slot = '0;
  logic [1:0]  cfg_mode = '0;
  logic [15:0] cfg_addr = '0;
  logic [10:0] cfg_len = '0;
  logic [15:0] cfg_cnt = '0;
  logic        req = 1'b0;
  logic [3:0]  req_prog = '0;
  logic        req_now = 1'b0;
  logic        mem_en, out_valid, done;
  logic [15:0] mem_addr;
  logic [31:0] out_data;
  logic [31:0] mem_q = '0;

  pat_seq u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_prog(cfg_prog), .cfg_slot(cfg_slot), .cfg_mode(cfg_mode),
    .cfg_addr(cfg_addr), .cfg_len(cfg_len), .cfg_cnt(cfg_cnt),
    .req(req), .req_prog(req_prog), .req_now(req_now),
    .mem_en(mem_en), .mem_addr(mem_addr), .mem_rdata(mem_q),
    .out_valid(out_valid), .out_data(out_data), .done(done)
  );

  function automatic logic [31:0] mdata(logic [15:0] a);
    return {a ^ 16'h5A3C, a};
  endfunction

  always_ff @(posedge clk) if (mem_en) mem_q <= mdata(mem_addr);

  int tests = 0;
  int fails = 0;
  int b_mode [16][4];
  int b_addr [16][4];
  int b_len  [16][4];
  int b_cnt  [16][4];
  int gq[$];
  bit ge[$];
  int ex[$];

  task automatic chk(bit ok, string tag, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(int p, int s, int m, int a, int w, int n);
    @(negedge clk);
    cfg_we = 1'b1; cfg_prog = 4'(p); cfg_slot = 2'(s); cfg_mode = 2'(m);
    cfg_addr = 16'(a); cfg_len = 11'(w - 1); cfg_cnt = 16'(n - 1);
    b_mode[p][s] = m; b_addr[p][s] = a; b_len[p][s] = w; b_cnt[p][s] = n;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic void gen(int p, int cap);
    gq.delete(); ge.delete();
    for (int s = 0; s < 4; s++) begin
      int plays;
      if (b_mode[p][s] == 0) return;
      plays = (b_mode[p][s] == 1) ? 1 : (b_mode[p][s] == 2) ? b_cnt[p][s] : 1 << 30;
      for (int r = 0; r < plays; r++)
        for (int w = 0; w < b_len[p][s]; w++) begin
          if (gq.size() >= cap) return;
          gq.push_back((b_addr[p][s] + w) & 16'hFFFF);
          ge.push_back(w == b_len[p][s] - 1);
        end
    end
  endfunction

  function automatic void take(int upto);
    for (int j = 0; j <= upto && j < gq.size(); j++) ex.push_back(gq[j]);
  endfunction

  function automatic int cut_at(int k);
    for (int j = k + 1; j < gq.size(); j++) if (ge[j]) return j;
    return gq.size() - 1;
  endfunction

  task automatic play(string tag, int sp, bit snow, int k1, int p1, bit n1,
                      int k2, int p2, bit fin);
    @(negedge clk);
    req = 1'b1; req_prog = 4'(sp); req_now = snow;
    @(negedge clk);
    req = 1'b0;
    for (int i = 0; i < ex.size(); i++) begin
      @(negedge clk);
      req = 1'b0;
      chk(out_valid === 1'b1 && done === 1'b0 && out_data === mdata(16'(ex[i])),
          tag, {out_valid, out_data}, {1'b1, mdata(16'(ex[i]))});
      if (i == k1) begin req = 1'b1; req_prog = 4'(p1); req_now = n1; end
      if (i == k2) begin req = 1'b1; req_prog = 4'(p2); req_now = 1'b0; end
    end
    if (fin) begin
      @(negedge clk);
      req = 1'b0;
      chk(done === 1'b1 && out_valid === 1'b0, {tag, " R5 done after last word"},
          {done, out_valid}, 2'b10);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int k, b, m;
    void'($urandom(32'd4242));
    for (int p = 0; p < 16; p++)
      for (int s = 0; s < 4; s++) begin
        b_mode[p][s] = 0; b_addr[p][s] = 0; b_len[p][s] = 1; b_cnt[p][s] = 1;
      end
    repeat (2) @(negedge clk);
    chk(out_valid === 1'b0 && done === 1'b0 && mem_en === 1'b0, "R1 in reset",
        {out_valid, done, mem_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0 && done === 1'b0 && mem_en === 1'b0, "R1 after reset",
        {out_valid, done, mem_en}, 0);

    // R10 table setup
    cfg(1, 0, 1, 'h0100, 16, 1);
    cfg(1, 1, 2, 'h0400, 16, 3);
    cfg(1, 2, 1, 'h0800, 20, 1);
    for (int s = 0; s < 4; s++) cfg(2, s, 1, 'h1000 + s * 'h100, 16 + s, 1);
    cfg(4, 0, 1, 'h3000, 16, 1);
    cfg(4, 1, 3, 'h3400, 16, 1);
    cfg(4, 2, 1, 'h3800, 16, 1);

    // R2 R3 R6 R10: once, count, once, then unused slot ends
    ex.delete(); gen(1, 100000); take(gq.size() - 1);
    play("R2 R3 R6 R10 program 1", 1, 1'b1, -1, 0, 1'b0, -1, 0, 1'b1);

    // R5: all four slots used, ends after the last slot
    ex.delete(); gen(2, 100000); take(gq.size() - 1);
    play("R5 program 2", 2, 1'b1, -1, 0, 1'b0, -1, 0, 1'b1);

    // R11: empty program
    @(negedge clk); req = 1'b1; req_prog = 4'd3; req_now = 1'b1;
    @(negedge clk); req = 1'b0;
    chk(done === 1'b1 && out_valid === 1'b0, "R11 empty program", {done, out_valid}, 2'b10);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(done === 1'b1 && out_valid === 1'b0, "R11 empty program stays", {done, out_valid}, 2'b10);
    end

    // R4 then R7: forever slot, then immediate switch
    k = 150;
    ex.delete(); gen(4, 1000); take(k + 1); gen(1, 100000); take(gq.size() - 1);
    play("R4 R7 forever then immediate", 4, 1'b1, k, 1, 1'b1, -1, 0, 1'b1);

    // R8: deferred mid segment
    k = 5;
    ex.delete(); gen(2, 100000); b = cut_at(k); take(b); gen(1, 100000); take(gq.size() - 1);
    play("R8 deferred mid segment", 2, 1'b1, k, 1, 1'b0, -1, 0, 1'b1);

    // R8: deferred in the last-word cycle
    k = 14;
    ex.delete(); gen(2, 100000); b = cut_at(k); take(b); gen(1, 100000); take(gq.size() - 1);
    play("R8 deferred on last word", 2, 1'b1, k, 1, 1'b0, -1, 0, 1'b1);

    // R8: deferred one word late, waits for next pass
    k = 15;
    ex.delete(); gen(2, 100000); b = cut_at(k); take(b); gen(1, 100000); take(gq.size() - 1);
    play("R8 deferred after boundary", 2, 1'b1, k, 1, 1'b0, -1, 0, 1'b1);

    // R9: second deferred request replaces the first, inside a forever pass
    ex.delete(); gen(4, 1000); b = cut_at(20); take(b); gen(1, 100000); take(gq.size() - 1);
    play("R9 replaced pending request", 4, 1'b1, 20, 2, 1'b0, 25, 1, 1'b1);

    // R11: deferred request while idle starts at once
    ex.delete(); gen(2, 100000); take(gq.size() - 1);
    play("R11 idle deferred start", 2, 1'b0, -1, 0, 1'b0, -1, 0, 1'b1);

    // R2 R3 R7 R8: random programs and switch points
    for (int r = 0; r < 8; r++) begin
      bit now;
      for (int p = 5; p < 7; p++)
        for (int s = 0; s < 4; s++) begin
          m = (s == 0) ? 1 + int'($urandom % 2) : int'($urandom % 3);
          cfg(p, s, m, int'($urandom % 'hF000), 16 + int'($urandom % 9), 1 + int'($urandom % 3));
        end
      gen(5, 100000);
      k = int'($urandom % (gq.size() / 2));
      now = 1'($urandom % 2);
      ex.delete();
      if (now) take(k + 1); else take(cut_at(k));
      gen(6, 100000); take(gq.size() - 1);
      play("R2 R3 R7 R8 random switch", 5, 1'b1, k, 6, now, -1, 0, 1'b1);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule